// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a simple clocked request/acknowledge host port and an external asynchronous static RAM of 512K words of 16 bits. It handles single-word reads and writes. It produces a 19-bit address, three active-low strobes (chip select, write strobe and output enable) and a data bus split into an outbound value, an inbound value and a drive enable. A pad ring can merge these into a tristate pin.

The RAM's timing limits are given as nanosecond parameters, together with the controller's clock period. At elaboration the controller rounds each limit up to whole clock cycles. It then holds every strobe for at least that many cycles.

- Reads: the controller waits out the access time before it samples the bus.
- Writes: the write strobe rises only after the minimum pulse width, data setup and address setup have all been met.
- Turnaround: after a read, the controller waits for the RAM to release the bus before it drives any write data onto it.

The host raises `host_req` with its command and keeps the command stable until `host_ack` pulses for one cycle. On a read, `host_rdata` is valid in that same cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, chip select, write strobe and output enable are all high (inactive), `sram_dq_oe` is 0 and `host_ack` is 0.
- R2: A read (`host_req`=1, `host_we`=0) accepted at clock edge k drives the address, chip select low and output enable low, with the write strobe held high. The bus is sampled into `host_rdata` at edge k+C_RD, where C_RD is the largest of ceil(tRC), ceil(tAA) and ceil(tOE) in clock periods, and at least 1. `host_ack` is high for exactly one cycle, in that same edge, and the read data equals the last value written to that address.
- R3: A write (`host_req`=1, `host_we`=1) accepted at edge k drives the address, chip select low and the write data with `sram_dq_oe`=1, all at edge k. The write strobe falls at edge k+1 and stays low only while chip select is low, output enable is high and the bus is driven.
- R4: The write strobe stays low for C_WP cycles, where C_WP = max(ceil(tWP), ceil(tDW)-1, ceil(tAW)-1) and at least 1. When it rises, it has been low for at least ceil(tWP) cycles, the data has been stable for at least ceil(tDW) cycles, and the address and chip select have been valid for at least ceil(tAW) cycles.
- R5: The bus stays driven and chip select stays low in the cycle in which the write strobe rises. Chip select is low for at least ceil(tWC) cycles per write. `host_ack` comes at edge k+1+C_WP+C_WH, where C_WH = max(1, ceil(tWC)-1-C_WP).
- R6: After output enable rises at the end of a read, the controller does not drive the bus for at least C_HZ+1 cycles, where C_HZ = max(1, ceil(tHZ)). A write requested right after a read is therefore acknowledged later, by the part of that window still left; a read requested right after a read is not delayed.
- R7: The controller never drives the bus while output enable is low.
- R8: With `host_req` low, all strobes stay inactive and the bus is not driven.
- R9: The address does not change while chip select is low. Chip select returns high for at least one cycle between two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with the acknowledge |
| sram_addr | output | 19 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 16 | Data returned by the RAM |

## Verification
A phase counter that is loaded with the wrong value, or a sequencer that skips a state, shows up within the very transaction it affects. The acknowledge arrives a cycle early or late, a read returns the RAM model's not-yet-valid filler word, or the RAM model sees a strobe width shorter than its rounded-up minimum at the rising edge of that strobe. A turnaround counter that is stuck or cleared early shows up in the first write issued straight after a read, either as a late or early acknowledge or as bus drive that overlaps the RAM's release window. A lost write shows up only at the next read of that address, which the random mix of reads and writes over a small address pool reaches within a few transactions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_e;

  // one-cycle commands from the sequencer to the pin register stage
  typedef struct packed {
    logic take_rd;
    logic take_wr;
    logic we_fall;
    logic we_rise;
    logic wr_done;
    logic rd_done;
  } io_cmd_t;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CW   = 4,
  parameter int C_RD = 1,
  parameter int C_WP = 1,
  parameter int C_WH = 1,
  parameter int C_HZ = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          ph_zero,
  input  logic          hz_zero,
  output io_cmd_t       cmd,
  output logic          ph_load,
  output logic [CW-1:0] ph_val,
  output logic          hz_load,
  output logic [CW-1:0] hz_val
);

  seq_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d    = st_q;
    cmd     = '0;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req && !req_we) begin
          cmd.take_rd = 1'b1;
          ph_load     = 1'b1;
          ph_val      = CW'(C_RD - 1);
          st_d        = ST_READ;
        end else if (req && req_we && hz_zero) begin
          // bus is free of the RAM's output drivers
          cmd.take_wr = 1'b1;
          st_d        = ST_WSETUP;
        end
      end
      ST_READ: begin
        if (ph_zero) begin
          cmd.rd_done = 1'b1;
          st_d        = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        cmd.we_fall = 1'b1;
        ph_load     = 1'b1;
        ph_val      = CW'(C_WP - 1);
        st_d        = ST_WPULSE;
      end
      ST_WPULSE: begin
        if (ph_zero) begin
          cmd.we_rise = 1'b1;
          ph_load     = 1'b1;
          ph_val      = CW'(C_WH - 1);
          st_d        = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        if (ph_zero) begin
          cmd.wr_done = 1'b1;
          st_d        = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // release window starts when output enable is withdrawn
  assign hz_load = cmd.rd_done;
  assign hz_val  = CW'(C_HZ);

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  io_cmd_t       cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  output logic          ack,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr   <= '0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      ack         <= 1'b0;
      rdata       <= '0;
    end else begin
      ack <= 1'b0;
      if (cmd.take_rd || cmd.take_wr) begin
        sram_addr <= req_addr;
        sram_ce_n <= 1'b0;
      end
      if (cmd.take_rd) sram_oe_n <= 1'b0;
      if (cmd.take_wr) begin
        sram_dq_out <= req_wdata;
        sram_dq_oe  <= 1'b1;
      end
      if (cmd.we_fall) sram_we_n <= 1'b0;
      if (cmd.we_rise) sram_we_n <= 1'b1;
      if (cmd.wr_done) begin
        sram_dq_oe <= 1'b0;
        sram_ce_n  <= 1'b1;
        ack        <= 1'b1;
      end
      if (cmd.rd_done) begin
        rdata     <= dq_in;
        sram_oe_n <= 1'b1;
        sram_ce_n <= 1'b1;
        ack       <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 19,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_OE_NS       = 4,
  parameter int T_WC_NS       = 10,
  parameter int T_WP_NS       = 7,
  parameter int T_AW_NS       = 7,
  parameter int T_DW_NS       = 5,
  parameter int T_HZ_NS       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int C_RD = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_OE_NS, CLK_PERIOD_NS))));
  // data, address and select are set up one cycle before the strobe falls
  localparam int C_WP = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                imax(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS) - 1,
                                     ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - 1)));
  localparam int C_WH  = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - C_WP);
  localparam int C_HZ  = imax(1, ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));
  localparam int C_MAX = imax(imax(C_RD, C_WP), imax(C_WH, C_HZ));
  localparam int CW    = $clog2(C_MAX + 1);

  io_cmd_t       cmd;
  logic          ph_load, ph_zero, hz_load, hz_zero;
  logic [CW-1:0] ph_val, hz_val;

  sram_ctrl_seq #(
    .CW(CW), .C_RD(C_RD), .C_WP(C_WP), .C_WH(C_WH), .C_HZ(C_HZ)
  ) u_seq (
    .clk(clk), .rst(rst), .req(host_req), .req_we(host_we),
    .ph_zero(ph_zero), .hz_zero(hz_zero), .cmd(cmd),
    .ph_load(ph_load), .ph_val(ph_val), .hz_load(hz_load), .hz_val(hz_val)
  );

  sram_ctrl_cnt #(.W(CW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  sram_ctrl_cnt #(.W(CW)) u_turn (
    .clk(clk), .rst(rst), .load(hz_load), .load_val(hz_val), .zero(hz_zero)
  );

  sram_ctrl_io #(.AW(AW), .DW(DW)) u_io (
    .clk(clk), .rst(rst), .cmd(cmd), .req_addr(host_addr), .req_wdata(host_wdata),
    .dq_in(sram_dq_in), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .ack(host_ack), .rdata(host_rdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 19,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_HZ_NS       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          ack,
  input logic [AW-1:0] addr
);

  localparam int HZ_CYC = imax(1, ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));

  logic oe_n_d;
  int   since_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n_d   <= 1'b1;
      since_oe <= 255;
    end else begin
      oe_n_d <= oe_n;
      if (oe_n && !oe_n_d)  since_oe <= 1;
      else if (since_oe < 255) since_oe <= since_oe + 1;
    end
  end

  // R7
  bus_vs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R3
  we_context_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && oe_n && dq_oe));

  // R5
  hold_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && !ce_n));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R2
  read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ce_n && we_n));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> (since_oe > HZ_CYC));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW(AW), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_HZ_NS(T_HZ_NS)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
  .dq_oe(sram_dq_oe), .ack(host_ack), .addr(sram_addr)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int PER  = 3;
  localparam int T_RC = 10, T_AA = 10, T_OE = 4, T_WC = 10;
  localparam int T_WP = 7, T_AW = 7, T_DW = 5, T_HZ = 4;

  function automatic int cyc(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int VAL_B  = mx(cyc(T_AA), cyc(T_OE));
  localparam int C_RD_B = mx(1, mx(cyc(T_RC), VAL_B));
  localparam int C_WP_B = mx(1, mx(cyc(T_WP), mx(cyc(T_DW) - 1, cyc(T_AW) - 1)));
  localparam int C_WH_B = mx(1, cyc(T_WC) - 1 - C_WP_B);
  localparam int C_HZ_B = mx(1, cyc(T_HZ));
  localparam int RD_LAT = C_RD_B + 1;
  localparam int WR_LAT = 2 + C_WP_B + C_WH_B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0, h_we = 1'b0, h_ack;
  logic [18:0] h_addr = '0, s_addr;
  logic [15:0] h_wdata = '0, h_rdata, s_dout;
  logic [15:0] ram_q = 16'hDEAD;
  logic        ce_n, we_n, oe_n, dq_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_ctrl #(
    .CLK_PERIOD_NS(PER), .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_OE_NS(T_OE),
    .T_WC_NS(T_WC), .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DW_NS(T_DW), .T_HZ_NS(T_HZ)
  ) u_dut (
    .clk(clk), .rst(rst), .host_req(h_req), .host_we(h_we), .host_addr(h_addr),
    .host_wdata(h_wdata), .host_ack(h_ack), .host_rdata(h_rdata),
    .sram_addr(s_addr), .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_dq_out(s_dout), .sram_dq_oe(dq_oe), .sram_dq_in(ram_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] seed_word(input logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h1A5B};
  endfunction

  // behavioural RAM
  logic [15:0] ram_mem [logic [18:0]];
  logic [15:0] shadow  [logic [18:0]];

  function automatic logic [15:0] ram_get(input logic [18:0] a);
    return ram_mem.exists(a) ? ram_mem[a] : seed_word(a);
  endfunction
  function automatic logic [15:0] shadow_get(input logic [18:0] a);
    return shadow.exists(a) ? shadow[a] : seed_word(a);
  endfunction

  logic        p_we_n = 1, p_ce_n = 1, p_dq_oe = 0, p_ack = 0, p_rd = 0;
  logic [18:0] p_addr = '0;
  logic [15:0] p_dout = '0;
  int  we_lo = 0, ce_lo = 0, addr_st = 0, data_st = 0, rd_cnt = 0, tail = 0;
  bit  wr_win = 0, addr_moved = 0, rd_c;

  always @(negedge clk) begin
    if (!rst) begin
      rd_c = !ce_n && !oe_n && we_n;
      if (dq_oe && !p_dq_oe) begin
        chk(!rd_c && tail == 0, "R6 bus driven inside RAM release window", tail, 0);
        chk(oe_n, "R7 bus driven while output enable low", oe_n, 1);
      end
      if (!we_n && p_we_n)
        chk(oe_n && !ce_n && dq_oe, "R3 write strobe context", {oe_n, ce_n, dq_oe}, 3'b101);
      if (we_n && !p_we_n) begin
        chk(we_lo >= cyc(T_WP), "R4 write pulse width", we_lo, cyc(T_WP));
        chk(data_st >= cyc(T_DW), "R4 data setup", data_st, cyc(T_DW));
        chk(ce_lo >= cyc(T_AW) && addr_st >= cyc(T_AW), "R4 address/select setup",
            mx(0, ce_lo < addr_st ? ce_lo : addr_st), cyc(T_AW));
        chk(dq_oe, "R5 data held at strobe rise", dq_oe, 1);
        ram_mem[s_addr] = s_dout;
      end
      if (ce_n && !p_ce_n) begin
        if (wr_win) chk(ce_lo >= cyc(T_WC), "R5 write cycle length", ce_lo, cyc(T_WC));
        else        chk(ce_lo >= cyc(T_RC), "R2 read cycle length", ce_lo, cyc(T_RC));
        chk(!addr_moved, "R9 address moved under select", addr_moved, 0);
      end
      if (p_ack) chk(!h_ack, "R2 ack lasts one cycle", h_ack, 0);

      we_lo   = !we_n ? (p_we_n ? 1 : we_lo + 1) : 0;
      ce_lo   = !ce_n ? (p_ce_n ? 1 : ce_lo + 1) : 0;
      addr_st = !ce_n ? ((!p_ce_n && s_addr == p_addr) ? addr_st + 1 : 1) : 0;
      data_st = dq_oe ? ((p_dq_oe && s_dout == p_dout) ? data_st + 1 : 1) : 0;
      if (!ce_n && !p_ce_n && s_addr != p_addr) addr_moved = 1;
      if (!we_n) wr_win = 1;
      if (ce_n) begin wr_win = 0; addr_moved = 0; end
      rd_cnt = rd_c ? ((p_rd && s_addr == p_addr) ? rd_cnt + 1 : 1) : 0;
      ram_q  = (rd_c && rd_cnt >= VAL_B) ? ram_get(s_addr) : 16'hDEAD;
      if (rd_c) tail = C_HZ_B;
      else if (tail > 0) tail--;
      p_we_n = we_n; p_ce_n = ce_n; p_dq_oe = dq_oe; p_ack = h_ack;
      p_rd = rd_c; p_addr = s_addr; p_dout = s_dout;
    end
  end

  bit prev_was_rd = 0;

  task automatic host_op(input bit is_wr, input logic [18:0] a, input logic [15:0] d,
                         input int gap);
    int lat, exp_lat;
    repeat (gap) @(negedge clk);
    exp_lat = is_wr ? WR_LAT + (prev_was_rd ? mx(0, C_HZ_B - gap) : 0) : RD_LAT;
    h_req = 1'b1; h_we = is_wr; h_addr = a; h_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!h_ack && lat < 100);
    h_req = 1'b0;
    if (is_wr) begin
      chk(lat == exp_lat, prev_was_rd ? "R6 write-after-read latency" : "R5 write latency",
          lat, exp_lat);
      shadow[a] = d;
    end else begin
      chk(lat == exp_lat, "R2 read latency", lat, exp_lat);
      chk(h_rdata == shadow_get(a), "R2 read data", h_rdata, shadow_get(a));
    end
    prev_was_rd = !is_wr;
  endtask

  logic [18:0] pool [8];

  initial begin
    void'($urandom(32'd5173));
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001; pool[3] = 19'h40000;
    pool[4] = 19'h2AAAA; pool[5] = 19'h55555; pool[6] = 19'h0FFF0; pool[7] = 19'h12345;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n && we_n && oe_n && !dq_oe && !h_ack, "R1 strobes during reset",
        {ce_n, we_n, oe_n, dq_oe, h_ack}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe && !h_ack, "R1 state after reset",
        {ce_n, we_n, oe_n, dq_oe, h_ack}, 5'b11100);
    // R8 idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ce_n && we_n && oe_n && !dq_oe, "R8 idle without request",
          {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    end
    // directed corners
    host_op(1'b0, 19'h00005, 16'h0, 0);
    host_op(1'b1, 19'h00000, 16'h0000, 0);
    host_op(1'b1, 19'h7FFFF, 16'hFFFF, 0);
    host_op(1'b0, 19'h00000, 16'h0, 0);
    host_op(1'b0, 19'h7FFFF, 16'h0, 0);
    host_op(1'b1, 19'h7FFFF, 16'h8001, 0);
    host_op(1'b0, 19'h7FFFF, 16'h0, 1);
    host_op(1'b1, 19'h00001, 16'h1234, 1);
    host_op(1'b0, 19'h00001, 16'h0, 3);
    host_op(1'b1, 19'h00002, 16'hA5A5, 4);
    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [18:0] a;
      bit          w;
      w = ($urandom_range(0, 1) == 1);
      a = ($urandom_range(0, 3) == 0) ? 19'($urandom()) : pool[$urandom_range(0, 7)];
      host_op(w, a, 16'($urandom()), $urandom_range(0, 3));
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule